// File: doc/BRIEF.md
# External Interrupt Request Latch

This block is the external interrupt front end of a small microcontroller. It takes one dedicated active-low interrupt pin and a group of general-purpose port pins, synchronizes them, and merges the enabled ones into a single active request with one OR. A falling edge of that merged request sets a sticky request latch. In level mode, the latch is also set on every cycle that the merged request stays active. The latch, gated by a software enable bit and the CPU's interrupt mask, becomes the interrupt request to the CPU.

Three things clear the latch: reset, a write of 1 to the acknowledge bit of the status/control register, and the CPU fetching the interrupt vector. Because the vector fetch clears the latch, a fresh request can be captured while the service routine runs. That request is then taken as soon as the CPU unmasks interrupts again. The synchronized level of the dedicated pin is also exported so that branch-on-pin instructions can test it.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, status bit 0 (flag) and bit 1 (enable) read 0, and `irqReq` is 0.
- R2: In edge mode, a falling edge on `irqPinN` sets the flag at the third rising clock edge after the pin changes. Holding the pin low after the flag is acknowledged does not set it again.
- R3: The port pins `portPinN` can set the flag only while `cfgPortEn` is 1. While `cfgPortEn` is 0, a falling port pin leaves the flag at 0.
- R4: With `cfgLevelMode` at 1, an acknowledge has no effect while the merged request is still active. Once the pins are released, an acknowledge clears the flag.
- R5: Writing a status word with bit 2 (acknowledge) set clears the flag at that clock edge. The same write stores bit 1 as the enable. Bit 2 always reads 0.
- R6: A fetch cycle (`cpuFetchEn`=1) at address 0x07FA or 0x07FB raises `vecFetch` in that cycle and clears the flag at the next edge. Fetches at other addresses leave the flag unchanged.
- R7: `irqReq` is 1 exactly when the flag is 1, the enable bit is 1 and `cpuIMask` is 0.
- R8: If a new set event and a clear (acknowledge or vector fetch) occur at the same edge, the flag ends up set.
- R9: A falling edge that arrives after the vector-fetch clear is latched while `cpuIMask` is 1. `irqReq` rises in the same cycle that `cpuIMask` falls.
- R10: `pinLevel` equals the level of `irqPinN` delayed by the two synchronizer stages, and it is 1 for a high pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 1 | Dedicated interrupt pin, active low |
| portPinN | input | NUM_PORT | Port pins usable as interrupt sources, active low |
| cfgPortEn | input | 1 | Mask option: let the port pins join the request |
| cfgLevelMode | input | 1 | Mask option: level-sensitive as well as edge triggering |
| regWrEn | input | 1 | Status/control register write strobe |
| regWrData | input | DATA_W | Write data: bit 1 enable, bit 2 acknowledge |
| regRdData | output | DATA_W | Read data: bit 0 flag, bit 1 enable, bit 2 reads 0 |
| cpuIMask | input | 1 | CPU interrupt mask bit, 1 blocks requests |
| cpuFetchEn | input | 1 | CPU fetch cycle valid |
| cpuFetchAddr | input | ADDR_W | CPU fetch address |
| irqReq | output | 1 | Gated interrupt request to the CPU |
| vecFetch | output | 1 | Interrupt vector fetch detected |
| pinLevel | output | 1 | Synchronized level of the dedicated pin |

## Verification
The hardest case to reach is the collision of a set event and a clear at the same clock edge. A set event occurs only in the single cycle after a falling edge has crossed both synchronizer stages. The bench starts with the flag already set and the pin released. It then drops the pin on a falling clock edge and raises the acknowledge write exactly two clock cycles later, so that the write lands on the edge where the set event is live. The service-time re-capture case is reached by running a complete vector fetch with the mask held. A second edge is then produced before the mask is dropped.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  typedef struct packed {
    logic clrLatch;
    logic fetchHit;
  } irqStrobes_t;

  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int ACK_BIT  = 2;
endpackage

// File: rtl/irq_front_dp.sv
module irq_front_dp
  import irq_front_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic                cfgPortEn,
  input  logic                cfgLevelMode,
  input  irqStrobes_t         strb,
  output logic                latchQ,
  output logic                setEv,
  output logic                pinLevel
);
  localparam int NUM_SRC = NUM_PORT + 1;

  logic [NUM_SRC-1:0] pinsRaw;
  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES];
  logic [NUM_SRC-1:0] syncOut;
  logic [NUM_SRC-1:0] srcMask;
  logic               reqNow;
  logic               prevReq;

  assign pinsRaw = {portPinN, irqPinN};

  // Synchronizer chain, one register per stage; idle pins reset high.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[g] <= '1;
      else if (g == 0) syncStage[g] <= pinsRaw;
      else syncStage[g] <= syncStage[(g == 0) ? 0 : g-1];
    end
  end

  assign syncOut  = syncStage[SYNC_STAGES-1];
  assign srcMask  = {{NUM_PORT{cfgPortEn}}, 1'b1};
  assign reqNow   = |(~syncOut & srcMask);
  assign pinLevel = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReq <= 1'b0;
    else prevReq <= reqNow;
  end

  assign setEv = (reqNow & ~prevReq) | (cfgLevelMode & reqNow);

  // Request latch: a set event outranks any clear at the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= 1'b0;
    else if (setEv) latchQ <= 1'b1;
    else if (strb.clrLatch) latchQ <= 1'b0;
  end
endmodule

// File: rtl/irq_front_ctrl.sv
module irq_front_ctrl
  import irq_front_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_ADDR = 'h07FA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cpuIMask,
  input  logic              cpuFetchEn,
  input  logic [ADDR_W-1:0] cpuFetchAddr,
  input  logic              latchQ,
  output irqStrobes_t       strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq,
  output logic              vecFetch
);
  localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_ADDR + 1);

  logic enableQ;
  logic ackPulse;
  logic fetchHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= 1'b0;
    else if (regWrEn) enableQ <= regWrData[EN_BIT];
  end

  assign ackPulse = regWrEn & regWrData[ACK_BIT];
  assign fetchHit = cpuFetchEn &
                    ((cpuFetchAddr == VEC_HI_A) | (cpuFetchAddr == VEC_LO_A));

  always_comb begin
    strb.clrLatch = ackPulse | fetchHit;
    strb.fetchHit = fetchHit;
  end

  always_comb begin
    regRdData           = '0;
    regRdData[FLAG_BIT] = latchQ;
    regRdData[EN_BIT]   = enableQ;
  end

  assign irqReq   = latchQ & enableQ & ~cpuIMask;
  assign vecFetch = strb.fetchHit;
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import irq_front_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int VEC_ADDR    = 'h07FA
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic                cfgPortEn,
  input  logic                cfgLevelMode,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                cpuIMask,
  input  logic                cpuFetchEn,
  input  logic [ADDR_W-1:0]   cpuFetchAddr,
  output logic                irqReq,
  output logic                vecFetch,
  output logic                pinLevel
);
  irqStrobes_t strb;
  logic        latchQ;
  logic        setEv;

  irq_front_dp #(
    .NUM_PORT(NUM_PORT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .cfgPortEn(cfgPortEn), .cfgLevelMode(cfgLevelMode), .strb(strb),
    .latchQ(latchQ), .setEv(setEv), .pinLevel(pinLevel)
  );

  irq_front_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .cpuIMask(cpuIMask), .cpuFetchEn(cpuFetchEn), .cpuFetchAddr(cpuFetchAddr),
    .latchQ(latchQ), .strb(strb), .regRdData(regRdData), .irqReq(irqReq),
    .vecFetch(vecFetch)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
  import irq_front_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              cpuIMask,
  input logic [DATA_W-1:0] regRdData,
  input logic              latchQ,
  input logic              setEv,
  input logic              clrLatch
);
  p_req_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (latchQ && regRdData[EN_BIT] && !cpuIMask));

  p_flag_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[FLAG_BIT] == latchQ);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    setEv |=> latchQ);

  p_rise_needs_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchQ) |-> $past(setEv));

  p_clear_works_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrLatch && !setEv) |=> !latchQ);

  p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[ACK_BIT]);
endmodule

bind ext_irq_front irq_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .cpuIMask(cpuIMask),
  .regRdData(regRdData), .latchQ(latchQ), .setEv(setEv),
  .clrLatch(strb.clrLatch)
);

// File: tb/tb_ext_irq_front.sv
`timescale 1ns/1ps
module tb_ext_irq_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqPinN = 1'b1;
  logic [3:0]  portPinN = 4'hF;
  logic        cfgPortEn = 1'b0;
  logic        cfgLevelMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        cpuIMask = 1'b1;
  logic        cpuFetchEn = 1'b0;
  logic [15:0] cpuFetchAddr = '0;
  logic        irqReq;
  logic        vecFetch;
  logic        pinLevel;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  ext_irq_front dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .cfgPortEn(cfgPortEn), .cfgLevelMode(cfgLevelMode), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cpuIMask(cpuIMask),
    .cpuFetchEn(cpuFetchEn), .cpuFetchAddr(cpuFetchAddr), .irqReq(irqReq),
    .vecFetch(vecFetch), .pinLevel(pinLevel)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    irqPinN = 1'b1; portPinN = 4'hF; cfgPortEn = 1'b0; cfgLevelMode = 1'b0;
    regWrEn = 1'b0; regWrData = '0; cpuIMask = 1'b1; cpuFetchEn = 1'b0;
    cpuFetchAddr = '0;
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic writeReg(input logic en, input logic ack);
    regWrData = {5'b0, ack, en, 1'b0};
    regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic fetchAt(input logic [15:0] addr, output logic seen);
    cpuFetchAddr = addr;
    cpuFetchEn = 1'b1;
    #1 seen = vecFetch;
    step(1);
    cpuFetchEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 flag", int'(regRdData[0]), 0);
    chk("R1 enable", int'(regRdData[1]), 0);
    chk("R1 irqReq", int'(irqReq), 0);
  endtask

  task automatic testEdge();
    doReset();
    irqPinN = 1'b0;
    step(2);
    chk("R2 flag not yet", int'(regRdData[0]), 0);
    step(1);
    chk("R2 flag set on third edge", int'(regRdData[0]), 1);
    writeReg(1'b0, 1'b1);
    chk("R5 ack clears", int'(regRdData[0]), 0);
    chk("R5 ack reads 0", int'(regRdData[2]), 0);
    step(3);
    chk("R2 held low no reset", int'(regRdData[0]), 0);
  endtask

  task automatic testPort();
    doReset();
    portPinN[1] = 1'b0;
    step(4);
    chk("R3 port ignored when disabled", int'(regRdData[0]), 0);
    portPinN[1] = 1'b1;
    step(3);
    cfgPortEn = 1'b1;
    step(1);
    portPinN[2] = 1'b0;
    step(3);
    chk("R3 port sets when enabled", int'(regRdData[0]), 1);
  endtask

  task automatic testLevel();
    doReset();
    cfgLevelMode = 1'b1;
    irqPinN = 1'b0;
    step(3);
    chk("R4 level set", int'(regRdData[0]), 1);
    writeReg(1'b0, 1'b1);
    chk("R4 ack while held", int'(regRdData[0]), 1);
    irqPinN = 1'b1;
    step(3);
    writeReg(1'b0, 1'b1);
    chk("R4 ack after release", int'(regRdData[0]), 0);
  endtask

  task automatic testFetch();
    logic seen;
    doReset();
    irqPinN = 1'b0;
    step(3);
    irqPinN = 1'b1;
    step(3);
    fetchAt(16'h07FC, seen);
    chk("R6 other addr no strobe", int'(seen), 0);
    chk("R6 other addr keeps flag", int'(regRdData[0]), 1);
    fetchAt(16'h07FB, seen);
    chk("R6 low vector strobe", int'(seen), 1);
    chk("R6 low vector clears", int'(regRdData[0]), 0);
    irqPinN = 1'b0;
    step(3);
    irqPinN = 1'b1;
    step(3);
    fetchAt(16'h07FA, seen);
    chk("R6 high vector strobe", int'(seen), 1);
    chk("R6 high vector clears", int'(regRdData[0]), 0);
  endtask

  task automatic testGate();
    doReset();
    cpuIMask = 1'b0;
    irqPinN = 1'b0;
    step(3);
    chk("R7 no enable", int'(irqReq), 0);
    writeReg(1'b1, 1'b0);
    chk("R5 enable stored", int'(regRdData[1]), 1);
    chk("R7 all conditions", int'(irqReq), 1);
    cpuIMask = 1'b1;
    #1 chk("R7 masked", int'(irqReq), 0);
    step(1);
  endtask

  task automatic testSetWins();
    doReset();
    irqPinN = 1'b0;
    step(3);
    irqPinN = 1'b1;
    step(3);
    irqPinN = 1'b0;
    step(2);
    writeReg(1'b0, 1'b1);
    chk("R8 set wins over ack", int'(regRdData[0]), 1);
    writeReg(1'b0, 1'b1);
    chk("R8 later ack clears", int'(regRdData[0]), 0);
  endtask

  task automatic testService();
    logic seen;
    doReset();
    cpuIMask = 1'b0;
    writeReg(1'b1, 1'b0);
    irqPinN = 1'b0;
    step(3);
    chk("R9 request raised", int'(irqReq), 1);
    cpuIMask = 1'b1;
    irqPinN = 1'b1;
    fetchAt(16'h07FA, seen);
    chk("R9 cleared by fetch", int'(regRdData[0]), 0);
    step(3);
    irqPinN = 1'b0;
    step(3);
    chk("R9 new edge latched", int'(regRdData[0]), 1);
    chk("R9 masked meanwhile", int'(irqReq), 0);
    cpuIMask = 1'b0;
    #1 chk("R9 taken on unmask", int'(irqReq), 1);
    step(1);
  endtask

  task automatic testPinLevel();
    doReset();
    chk("R10 idle high", int'(pinLevel), 1);
    irqPinN = 1'b0;
    step(1);
    chk("R10 one stage", int'(pinLevel), 1);
    step(1);
    chk("R10 two stages", int'(pinLevel), 0);
    irqPinN = 1'b1;
    step(2);
    chk("R10 back high", int'(pinLevel), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    step(1);
    testReset();
    testEdge();
    testPort();
    testLevel();
    testFetch();
    testGate();
    testSetWins();
    testService();
    testPinLevel();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule